// File: doc/BRIEF.md
# Transmit Checksum Offload Inserter

This block sits on the transmit path of an Ethernet MAC. Frame bytes arrive one per cycle and are written into a local frame buffer. A per-packet command arrives beforehand as a five-word sideband header. When the last byte of a frame arrives, the block can fold a 16-bit ones-complement checksum over a chosen span of the frame, add a seed to it and complement it. The result is placed into the frame at a chosen byte position as the buffered frame streams out.

A transmit control word sets three things: whether transmit is on, whether jumbo frames are allowed, and whether VLAN-tagged lengths are allowed. Writing its top bit restores the default setting and abandons any frame that is partly assembled. Frames that overflow the buffer, frames sent while transmit is off, and VLAN-length frames sent while both length options are off are all dropped silently. Every frame that is sent adds its length to a 64-bit byte total and raises a one-cycle completion pulse.

Top module: `tx_csum_inserter`

## Requirements
- R1: After reset, `tx_ctrl` reads 0x5800_0000 (bits 30, 28 and 27 set). `out_valid` is low, `in_ready` is high and `tx_bytes` is zero.
- R2: The sideband header is accepted one 32-bit word per `hdr_valid` cycle and takes effect once the fifth word arrives. Bit 0 of word 0 enables insertion. Word 1 holds the start offset in bits 31:16 and the insertion offset in bits 15:0. Word 2 holds the seed in bits 15:0. All other bits are ignored.
- R3: The checksum covers the bytes from the start offset up to the end of the frame. Bytes are paired into big-endian 16-bit words counted from the start offset, and an odd final byte is padded with zero. The seed is added, the carries are folded into 16 bits and the result is complemented. A start offset at or beyond the frame length gives the complement of the folded seed.
- R4: With insertion enabled, the high checksum byte replaces the frame byte at the insertion offset and the low byte replaces the next byte. A replacement byte that would fall at or beyond the frame length is not sent. With insertion disabled, the frame leaves unchanged.
- R5: While bit 28 of `tx_ctrl` is clear, frame bytes are accepted and discarded, and no frame is sent.
- R6: A byte that arrives when the buffer already holds DEPTH bytes of the current frame drops the whole frame, including the rest of it up to `in_last`. The write position returns to zero, and the next frame is handled normally. A frame of exactly DEPTH bytes is sent.
- R7: With both bit 30 (jumbo) and bit 27 (VLAN) of `tx_ctrl` clear, a frame longer than 1518 and at most 1522 bytes is dropped. Other lengths are sent, and either bit being set allows the 1519 to 1522 range.
- R8: A `ctrl_we` write with bit 31 set loads `tx_ctrl` with 0x5800_0000 and discards a frame that is partly assembled. Other writes store the value as written.
- R9: Each sent frame adds its length to `tx_bytes`. `frame_done` pulses in the first cycle that `out_valid` is high for that frame.
- R10: While a frame is being sent, `in_ready` is low. Outputs hold while `out_ready` is low. `out_last` marks the final byte, and the block returns to accepting bytes in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_we | input | 1 | Write strobe for the transmit control word |
| ctrl_wdata | input | 32 | Control word write data |
| tx_ctrl | output | 32 | Current transmit control word |
| hdr_valid | input | 1 | Sideband header word valid |
| hdr_data | input | 32 | Sideband header word |
| in_valid | input | 1 | Frame byte valid |
| in_ready | output | 1 | Block accepts frame bytes |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | Final byte of the frame |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream accepts output byte |
| out_data | output | 8 | Output byte, checksum inserted |
| out_last | output | 1 | Final output byte of the frame |
| tx_bytes | output | 64 | Running total of bytes sent |
| frame_done | output | 1 | One-cycle pulse per frame sent |

## Verification
The bench builds the block with its default DEPTH of 2048 bytes and the five-word header. At that depth the 1519 to 1522 byte policing window fits inside the buffer, so dropped and passed frames on both sides of each limit can be tried. The overflow boundary is also within reach: 2048 bytes passes and 2049 bytes drops, at a cost of a few thousand cycles. Random frames of up to 300 bytes cover start offsets beyond the frame end and insertion offsets at the last byte.

// File: rtl/txcso_pkg.sv
package txcso_pkg;

   localparam int CTRL_RST_BIT   = 31;
   localparam int CTRL_JUMBO_BIT = 30;
   localparam int CTRL_TXEN_BIT  = 28;
   localparam int CTRL_VLAN_BIT  = 27;

   localparam logic [31:0] CTRL_DEFAULT = 32'h5800_0000;

   localparam logic [16:0] LEN_STD_MAX  = 17'd1518;
   localparam logic [16:0] LEN_VLAN_MAX = 17'd1522;

   typedef struct packed {
      logic        ins_en;
      logic [15:0] start;
      logic [15:0] wpos;
      logic [15:0] seed;
   } csum_cmd_t;

   typedef enum logic [0:0] {
      ST_FILL = 1'b0,
      ST_SEND = 1'b1
   } tx_state_e;

   // Add seed, fold carries twice, complement.
   function automatic logic [15:0] csum_finish(input logic [31:0] acc,
                                               input logic [15:0] seed);
      logic [31:0] s;
      s = acc + {16'h0000, seed};
      s = {16'h0000, s[15:0]} + {16'h0000, s[31:16]};
      s = {16'h0000, s[15:0]} + {16'h0000, s[31:16]};
      return ~s[15:0];
   endfunction

endpackage

// File: rtl/txcso_hdr_capture.sv
module txcso_hdr_capture
   import txcso_pkg::*;
#(
   parameter int HDR_WORDS = 5
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        hdr_valid,
   input  logic [31:0] hdr_data,
   output csum_cmd_t   cmd
);

   localparam int IDX_W = $clog2(HDR_WORDS);

   logic [IDX_W-1:0] idx_q;
   logic             ins_sh;
   logic [15:0]      start_sh, wpos_sh, seed_sh;
   logic             ins_n;
   logic [15:0]      start_n, wpos_n, seed_n;
   logic             at_last;

   // Bypass the word arriving now so a commit sees all fields.
   always_comb begin
      ins_n   = (idx_q == IDX_W'(0)) ? hdr_data[0]     : ins_sh;
      start_n = (idx_q == IDX_W'(1)) ? hdr_data[31:16] : start_sh;
      wpos_n  = (idx_q == IDX_W'(1)) ? hdr_data[15:0]  : wpos_sh;
      seed_n  = (idx_q == IDX_W'(2)) ? hdr_data[15:0]  : seed_sh;
      at_last = (idx_q == IDX_W'(HDR_WORDS-1));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q    <= '0;
         ins_sh   <= 1'b0;
         start_sh <= '0;
         wpos_sh  <= '0;
         seed_sh  <= '0;
         cmd      <= '0;
      end else if (hdr_valid) begin
         ins_sh   <= ins_n;
         start_sh <= start_n;
         wpos_sh  <= wpos_n;
         seed_sh  <= seed_n;
         if (at_last) begin
            idx_q <= '0;
            cmd   <= '{ins_en: ins_n, start: start_n, wpos: wpos_n, seed: seed_n};
         end else begin
            idx_q <= idx_q + IDX_W'(1);
         end
      end
   end

endmodule

// File: rtl/txcso_sum_acc.sv
module txcso_sum_acc #(
   parameter int LEN_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             add_en,
   input  logic [LEN_W-1:0] idx,
   input  logic [15:0]      start,
   input  logic [7:0]       byte_in,
   output logic [31:0]      sum_next
);

   logic [31:0] acc_q;
   logic        in_span;
   logic        high_half;
   logic [15:0] term;

   always_comb begin
      in_span   = 16'(idx) >= start;
      high_half = (idx[0] ^ start[0]) == 1'b0;
      term      = high_half ? {byte_in, 8'h00} : {8'h00, byte_in};
      sum_next  = (add_en && in_span) ? acc_q + {16'h0000, term} : acc_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     acc_q <= '0;
      else if (clear) acc_q <= '0;
      else            acc_q <= sum_next;
   end

endmodule

// File: rtl/txcso_frame_buf.sv
module txcso_frame_buf #(
   parameter int DEPTH = 2048
) (
   input  logic                     clk,
   input  logic                     we,
   input  logic [$clog2(DEPTH)-1:0] waddr,
   input  logic [7:0]               wdata,
   input  logic [$clog2(DEPTH)-1:0] raddr,
   output logic [7:0]               rdata
);

   logic [7:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];

endmodule

// File: rtl/tx_csum_inserter.sv
module tx_csum_inserter
   import txcso_pkg::*;
#(
   parameter int DEPTH     = 2048,
   parameter int HDR_WORDS = 5,
   parameter int CNT_W     = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctrl_we,
   input  logic [31:0]       ctrl_wdata,
   output logic [31:0]       tx_ctrl,
   input  logic              hdr_valid,
   input  logic [31:0]       hdr_data,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [7:0]        in_data,
   input  logic              in_last,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [7:0]        out_data,
   output logic              out_last,
   output logic [CNT_W-1:0]  tx_bytes,
   output logic              frame_done
);

   localparam int ADDR_W = $clog2(DEPTH);
   localparam int LEN_W  = ADDR_W + 1;
   localparam logic [LEN_W-1:0] FULL_LEN = LEN_W'(DEPTH);

   generate
      if (DEPTH < 64 || DEPTH > 32768 || (1 << ADDR_W) != DEPTH) begin : g_bad_depth
         $error("DEPTH must be a power of two from 64 to 32768");
      end
      if (HDR_WORDS < 3) begin : g_bad_hdr
         $error("HDR_WORDS must be at least 3");
      end
      if (CNT_W < LEN_W) begin : g_bad_cnt
         $error("CNT_W must hold one frame length");
      end
   endgenerate

   tx_state_e        state_q;
   logic [31:0]      ctrl_q;
   logic [LEN_W-1:0] wr_pos_q, rd_pos_q, len_q;
   logic             drop_q;
   logic             ins_q;
   logic [15:0]      wpos_q, csum_q;
   logic [CNT_W-1:0] bytes_q;
   logic             done_q;

   csum_cmd_t        cmd;
   logic             soft_rst, take, overflow, store, oversize, launch, acc_clear;
   logic [LEN_W-1:0] frame_len;
   logic [16:0]      len_ext, rd_ext, wpos_ext;
   logic [31:0]      sum_next;
   logic [7:0]       buf_rdata;

   txcso_hdr_capture #(.HDR_WORDS(HDR_WORDS)) u_hdr (
      .clk       (clk),
      .rst_n     (rst_n),
      .hdr_valid (hdr_valid),
      .hdr_data  (hdr_data),
      .cmd       (cmd)
   );

   always_comb begin
      soft_rst  = ctrl_we && ctrl_wdata[CTRL_RST_BIT];
      take      = in_valid && (state_q == ST_FILL) && ctrl_q[CTRL_TXEN_BIT] && !soft_rst;
      overflow  = (wr_pos_q == FULL_LEN);
      store     = take && !drop_q && !overflow;
      frame_len = wr_pos_q + LEN_W'(1);
      len_ext   = 17'(frame_len);
      oversize  = !ctrl_q[CTRL_JUMBO_BIT] && !ctrl_q[CTRL_VLAN_BIT] &&
                  (len_ext > LEN_STD_MAX) && (len_ext <= LEN_VLAN_MAX);
      launch    = store && in_last && !oversize;
      acc_clear = soft_rst || (take && (in_last || drop_q || overflow));
   end

   txcso_sum_acc #(.LEN_W(LEN_W)) u_sum (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (acc_clear),
      .add_en   (store),
      .idx      (wr_pos_q),
      .start    (cmd.start),
      .byte_in  (in_data),
      .sum_next (sum_next)
   );

   txcso_frame_buf #(.DEPTH(DEPTH)) u_buf (
      .clk   (clk),
      .we    (store),
      .waddr (wr_pos_q[ADDR_W-1:0]),
      .wdata (in_data),
      .raddr (rd_pos_q[ADDR_W-1:0]),
      .rdata (buf_rdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= CTRL_DEFAULT;
      end else if (ctrl_we) begin
         ctrl_q <= ctrl_wdata[CTRL_RST_BIT] ? CTRL_DEFAULT : ctrl_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_FILL;
         wr_pos_q <= '0;
         rd_pos_q <= '0;
         len_q    <= '0;
         drop_q   <= 1'b0;
         ins_q    <= 1'b0;
         wpos_q   <= '0;
         csum_q   <= '0;
         bytes_q  <= '0;
         done_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (soft_rst) begin
            state_q  <= ST_FILL;
            wr_pos_q <= '0;
            rd_pos_q <= '0;
            drop_q   <= 1'b0;
         end else begin
            case (state_q)
               ST_FILL: begin
                  if (take) begin
                     if (drop_q || overflow) begin
                        wr_pos_q <= '0;
                        drop_q   <= !in_last;
                     end else if (in_last) begin
                        wr_pos_q <= '0;
                        if (launch) begin
                           state_q  <= ST_SEND;
                           len_q    <= frame_len;
                           rd_pos_q <= '0;
                           csum_q   <= csum_finish(sum_next, cmd.seed);
                           ins_q    <= cmd.ins_en;
                           wpos_q   <= cmd.wpos;
                           bytes_q  <= bytes_q + CNT_W'(frame_len);
                           done_q   <= 1'b1;
                        end
                     end else begin
                        wr_pos_q <= frame_len;
                     end
                  end
               end
               ST_SEND: begin
                  if (out_ready) begin
                     if (rd_pos_q == len_q - LEN_W'(1)) state_q <= ST_FILL;
                     else rd_pos_q <= rd_pos_q + LEN_W'(1);
                  end
               end
               default: state_q <= ST_FILL;
            endcase
         end
      end
   end

   // Checksum bytes are substituted on the way out of the buffer.
   always_comb begin
      rd_ext   = 17'(rd_pos_q);
      wpos_ext = {1'b0, wpos_q};
      if (ins_q && rd_ext == wpos_ext)
         out_data = csum_q[15:8];
      else if (ins_q && rd_ext == wpos_ext + 17'd1)
         out_data = csum_q[7:0];
      else
         out_data = buf_rdata;
   end

   assign tx_ctrl    = ctrl_q;
   assign in_ready   = (state_q == ST_FILL);
   assign out_valid  = (state_q == ST_SEND);
   assign out_last   = out_valid && (rd_pos_q == len_q - LEN_W'(1));
   assign tx_bytes   = bytes_q;
   assign frame_done = done_q;

endmodule

// File: rtl/txcso_checker.sv
module txcso_checker #(
   parameter int CNT_W = 64
) (
   input logic             clk,
   input logic             rst_n,
   input logic             soft_rst_req,
   input logic             ctrl_we,
   input logic [31:0]      tx_ctrl,
   input logic             in_ready,
   input logic             out_valid,
   input logic             out_ready,
   input logic [7:0]       out_data,
   input logic             out_last,
   input logic [CNT_W-1:0] tx_bytes,
   input logic             frame_done
);

   a_r5_tx_off_no_frame: assert property (@(posedge clk) disable iff (!rst_n)
      (!tx_ctrl[28] && !ctrl_we) |=> !frame_done);

   a_r8_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst_req |=> (tx_ctrl == 32'h5800_0000) && !out_valid);

   a_r9_count_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_done |-> tx_bytes == $past(tx_bytes));

   a_r9_count_grows: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |-> (tx_bytes > $past(tx_bytes)) && out_valid);

   a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready && !soft_rst_req) |=> out_valid && $stable(out_data) && $stable(out_last));

   a_r10_exit: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_ready && out_last) |=> !out_valid && in_ready);

endmodule

bind tx_csum_inserter txcso_checker #(.CNT_W(CNT_W)) u_txcso_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .soft_rst_req (ctrl_we && ctrl_wdata[31]),
   .ctrl_we      (ctrl_we),
   .tx_ctrl      (tx_ctrl),
   .in_ready     (in_ready),
   .out_valid    (out_valid),
   .out_ready    (out_ready),
   .out_data     (out_data),
   .out_last     (out_last),
   .tx_bytes     (tx_bytes),
   .frame_done   (frame_done)
);

// File: tb/tx_csum_inserter_test.sv
`timescale 1ns/1ps
module tx_csum_inserter_test;

   localparam int DEPTH = 2048;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ctrl_we = 1'b0;
   logic [31:0] ctrl_wdata = '0;
   logic [31:0] tx_ctrl;
   logic        hdr_valid = 1'b0;
   logic [31:0] hdr_data = '0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [7:0]  in_data = '0;
   logic        in_last = 1'b0;
   logic        out_valid;
   logic        out_ready = 1'b0;
   logic [7:0]  out_data;
   logic        out_last;
   logic [63:0] tx_bytes;
   logic        frame_done;

   always #5 clk = ~clk;

   tx_csum_inserter #(.DEPTH(DEPTH)) uut (
      .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
      .tx_ctrl(tx_ctrl), .hdr_valid(hdr_valid), .hdr_data(hdr_data),
      .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
      .in_last(in_last), .out_valid(out_valid), .out_ready(out_ready),
      .out_data(out_data), .out_last(out_last), .tx_bytes(tx_bytes),
      .frame_done(frame_done)
   );

   logic [7:0] pkt  [0:4095];
   logic [7:0] expb [0:4095];
   int     checks = 0;
   int     fails = 0;
   longint exp_total = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [15:0] ref_csum(input int len, input int start,
                                            input logic [15:0] seed);
      longint s = longint'(seed);
      for (int i = start; i < len; i += 2) begin
         s += longint'({pkt[i], (i + 1 < len) ? pkt[i+1] : 8'h00});
      end
      while ((s >> 16) != 0) s = (s & 64'hFFFF) + (s >> 16);
      return ~s[15:0];
   endfunction

   task automatic fill(input int len);
      for (int i = 0; i < len; i++) pkt[i] = 8'($urandom);
   endtask

   task automatic ctrl_write(input logic [31:0] v);
      @(negedge clk);
      ctrl_we = 1'b1; ctrl_wdata = v;
      @(posedge clk);
      @(negedge clk);
      ctrl_we = 1'b0;
   endtask

   task automatic send_hdr(input bit en, input int start, input int wpos,
                           input logic [15:0] seed);
      logic [31:0] w [5];
      w[0] = ($urandom & 32'hFFFF_FFFE) | 32'(en);
      w[1] = {16'(start), 16'(wpos)};
      w[2] = ($urandom & 32'hFFFF_0000) | 32'(seed);
      w[3] = $urandom;
      w[4] = $urandom;
      for (int k = 0; k < 5; k++) begin
         @(negedge clk);
         hdr_valid = 1'b1; hdr_data = w[k];
         @(posedge clk);
      end
      @(negedge clk);
      hdr_valid = 1'b0;
   endtask

   task automatic send_bytes(input int len, input bit eop);
      for (int i = 0; i < len; i++) begin
         @(negedge clk);
         in_valid = 1'b1; in_data = pkt[i]; in_last = eop && (i == len - 1);
         @(posedge clk);
      end
      @(negedge clk);
      in_valid = 1'b0; in_last = 1'b0;
   endtask

   task automatic build_exp(input int len, input bit en, input int start,
                            input int wpos, input logic [15:0] seed);
      logic [15:0] c;
      c = ref_csum(len, start, seed);
      for (int i = 0; i < len; i++) expb[i] = pkt[i];
      if (en && wpos < len)     expb[wpos]   = c[15:8];
      if (en && wpos + 1 < len) expb[wpos+1] = c[7:0];
   endtask

   task automatic expect_frame(input int len, input string req);
      int got = 0;
      int bad = 0;
      int lastbad = 0;
      int guard = 0;
      chk(out_valid === 1'b1 && frame_done === 1'b1, "R9", "frame start pulse",
          {out_valid, frame_done}, 3);
      exp_total += len;
      chk(tx_bytes == 64'(exp_total), "R9", "byte total", tx_bytes, exp_total);
      chk(in_ready === 1'b0, "R10", "in_ready while sending", in_ready, 0);
      while (got < len && guard < 20000) begin
         out_ready = ($urandom % 4) != 0;
         if (out_valid && out_ready) begin
            if (out_data !== expb[got]) bad++;
            if (out_last !== (got == len - 1)) lastbad++;
            got++;
         end
         @(posedge clk);
         @(negedge clk);
         guard++;
      end
      out_ready = 1'b0;
      chk(bad == 0, req, "mismatched output bytes", bad, 0);
      chk(lastbad == 0 && got == len, "R10", "last marker and byte count", got, len);
      chk(out_valid === 1'b0 && in_ready === 1'b1, "R10", "back to fill", out_valid, 0);
   endtask

   task automatic expect_drop(input string req);
      bit seen = 0;
      chk(out_valid === 1'b0 && frame_done === 1'b0, req, "dropped frame started",
          {out_valid, frame_done}, 0);
      repeat (4) begin
         @(negedge clk);
         if (out_valid !== 1'b0) seen = 1;
      end
      chk(!seen, req, "dropped frame sent later", seen, 0);
      chk(tx_bytes == 64'(exp_total), req, "byte total after drop", tx_bytes, exp_total);
   endtask

   task automatic run_frame(input int len, input bit en, input int start,
                            input int wpos, input logic [15:0] seed, input string req);
      fill(len);
      send_hdr(en, start, wpos, seed);
      build_exp(len, en, start, wpos, seed);
      send_bytes(len, 1'b1);
      expect_frame(len, req);
   endtask

   task automatic run_drop(input int len, input string req);
      fill(len);
      send_hdr(1'b1, 14, 20, 16'h0);
      send_bytes(len, 1'b1);
      expect_drop(req);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      fails++;
      checks++;
      $display("FAIL R10 watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk(tx_ctrl == 32'h5800_0000, "R1", "ctrl reset value", tx_ctrl, 32'h5800_0000);
      chk(out_valid === 1'b0 && in_ready === 1'b1, "R1", "idle handshake", {out_valid, in_ready}, 1);
      chk(tx_bytes == 64'd0, "R1", "byte total reset", tx_bytes, 0);

      // R2 R3 R4 directed checksum cases
      run_frame(60, 1'b1, 14, 24, 16'h1234, "R3 even span");
      run_frame(61, 1'b1, 14, 40, 16'hFFFF, "R3 odd tail pad");
      run_frame(48, 1'b0, 10, 20, 16'hABCD, "R4 insertion off");
      run_frame(50, 1'b1, 0, 49, 16'h0001, "R4 only high byte fits");
      run_frame(30, 1'b1, 40, 2, 16'h5A5A, "R3 start past end");
      run_frame(1, 1'b1, 0, 0, 16'h0000, "R4 single byte frame");

      // R2 R3 R4 R10 random mix
      for (int n = 0; n < 20; n++) begin
         int len = $urandom_range(1, 300);
         run_frame(len, ($urandom % 4) != 0, $urandom_range(0, len + 4),
                   $urandom_range(0, len), 16'($urandom), "R2 random frame");
      end

      // R7 policing with jumbo and VLAN both off
      ctrl_write(32'h1000_0000);
      chk(tx_ctrl == 32'h1000_0000, "R8", "plain ctrl write", tx_ctrl, 32'h1000_0000);
      run_drop(1519, "R7");
      run_drop(1522, "R7");
      run_frame(1518, 1'b1, 14, 30, 16'h0, "R7 standard max");
      run_frame(1523, 1'b1, 14, 30, 16'h0, "R7 above window");
      ctrl_write(32'h1800_0000);
      run_frame(1520, 1'b1, 14, 30, 16'h0, "R7 VLAN allowed");
      ctrl_write(32'h5000_0000);
      run_frame(1521, 1'b1, 14, 30, 16'h0, "R7 jumbo allowed");

      // R5 transmit disabled
      ctrl_write(32'h4800_0000);
      run_drop(40, "R5");
      ctrl_write(32'h5800_0000);
      run_frame(40, 1'b1, 14, 16, 16'h00FF, "R5 after re-enable");

      // R6 overflow and exact fit
      run_drop(DEPTH + 1, "R6");
      run_frame(64, 1'b1, 0, 10, 16'h0, "R6 after overflow");
      run_frame(DEPTH, 1'b1, 14, DEPTH - 2, 16'h7777, "R6 exact depth");

      // R8 soft reset abandons a partial frame
      fill(10);
      send_bytes(10, 1'b0);
      ctrl_write(32'h8000_0000);
      chk(tx_ctrl == 32'h5800_0000, "R8", "soft reset value", tx_ctrl, 32'h5800_0000);
      run_frame(30, 1'b1, 6, 8, 16'h1111, "R8 clean after reset");

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule